// File: doc/BRIEF.md
# Receive Statistics Counter and Interrupt Bank

This block keeps the receive-side statistics of an Ethernet MAC and turns them into one interrupt line. Each completed frame arrives as a one-cycle strobe. The strobe carries the frame length and flags for CRC error, oversize, broadcast, multicast and fragment. Further one-cycle strobes report FIFO overflow and underflow, code violations, link-fault events, and remote or local fault detection. The block counts frames, counts bytes and sorts frame lengths into seven histogram bins. It also keeps counters for error and fault events.

Each counter stops at its all-ones value and reports that it is full on a fixed bit of a sticky status word. The event strobes set status bits of their own. A mask word, where a one suppresses a source, gates the status bits into a registered interrupt. A host reaches the status word, the mask word and every counter through a simple register port. Reading the status word clears it. Writing a counter's address clears that counter.

Top module: `rxs_stat_irq_bank`

## Requirements
- R1: A frame strobe with a length of exactly 64 counts in bin 1, 65..127 in bin 2, 128..255 in bin 3, 256..511 in bin 4, 512..1023 in bin 5, 1024..1522 in bin 6 and above 1522 in bin 7. A length below 64 counts in no bin.
- R2: Each counter rises by one per qualified event, and the byte counter rises by the frame length. The error and link-fault counters default to 8 bits and the byte counter to 32 bits. Broadcast, multicast, fragment and bins 1, 2 and 7 default to 21 bits. Bins 3, 4, 5 and 6 default to 20, 19, 18 and 17 bits.
- R3: A counter that reaches all-ones stays at all-ones and never wraps, including when a byte increment would overshoot.
- R4: While a counter holds all-ones, its status bit is set on the next clock edge. The bits are CRC 3, oversize 4, bytes 6, bins 1..6 on bits 7..12, broadcast 13, multicast 14, fragment 15, link-fault 17 and bin 7 on bit 20.
- R5: The event strobes set status bits on the next edge: frame received 0, overflow 1, underflow 2, code violation 5, remote fault 18, local fault 19.
- R6: Status bits are sticky. A read of address 0 returns them and clears them on that edge. A source active in the same cycle sets its bit again.
- R7: A host write to a counter's address clears the counter, and the clear wins over an increment in the same cycle.
- R8: The mask resets to 0x1 and takes host writes to address 1 (bits 20..0). It reads back at address 1.
- R9: `irq` is high one cycle after any status bit is set while its mask bit is 0, and low otherwise.
- R10: Address 0 is status and 1 is mask. Addresses 2..15 hold the counters in the order CRC, oversize, bytes, bins 1..6, broadcast, multicast, fragment, link-fault, bin 7. Reads are zero-extended to 32 bits, other addresses read 0, and a write to address 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe: a frame finished |
| frm_len | input | 16 | Frame length in bytes |
| frm_crc_err | input | 1 | Frame had a CRC error |
| frm_oversize | input | 1 | Frame exceeded maximum size |
| frm_bcast | input | 1 | Frame was broadcast |
| frm_mcast | input | 1 | Frame was multicast |
| frm_frag | input | 1 | Frame was a fragment |
| evt_overflow | input | 1 | Receive FIFO overflow strobe |
| evt_underflow | input | 1 | Receive FIFO underflow strobe |
| evt_code_viol | input | 1 | Code violation strobe |
| evt_link_fault | input | 1 | Link-fault event strobe |
| evt_remote_fault | input | 1 | Remote fault detected strobe |
| evt_local_fault | input | 1 | Local fault detected strobe |
| host_wr | input | 1 | Host write enable |
| host_rd | input | 1 | Host read enable (clears status at address 0) |
| host_addr | input | 5 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| irq | output | 1 | Registered interrupt |

## Verification
On every cycle the assertions check the following: counters never wrap and hold when idle, a cleared counter reads zero, and strobes and full flags reach the sticky status word a cycle later. They also check that status does not lose bits without a read, that the interrupt follows unmasked status, and that unmapped addresses read zero. Other behaviour can only be shown by the bench's scenarios. These cover the exact histogram boundaries, byte sums that overshoot, set-wins-over-read-clear and clear-wins-over-increment collisions, the reset mask value, and the full address map. The bench compares the interrupt and the read data against its reference model on every clock.

// File: rtl/rxs_pkg.sv
`timescale 1ns/1ps
package rxs_pkg;
    localparam int NUM_CNT = 14;
    localparam int STAT_W  = 21;
    localparam int REG_W   = 32;
    localparam int LEN_W   = 16;

    // Counter index; the host address of a counter is CNT_BASE + index.
    typedef enum logic [3:0] {
        CI_CRC    = 4'd0,
        CI_MAXSZ  = 4'd1,
        CI_BYTES  = 4'd2,
        CI_H1     = 4'd3,
        CI_H2     = 4'd4,
        CI_H3     = 4'd5,
        CI_H4     = 4'd6,
        CI_H5     = 4'd7,
        CI_H6     = 4'd8,
        CI_BCAST  = 4'd9,
        CI_MCAST  = 4'd10,
        CI_FRAG   = 4'd11,
        CI_LFAULT = 4'd12,
        CI_H7     = 4'd13
    } cnt_idx_e;

    // Status positions of the event-driven sources.
    localparam int SB_FRAME  = 0;
    localparam int SB_OVF    = 1;
    localparam int SB_UNF    = 2;
    localparam int SB_CODEV  = 5;
    localparam int SB_RFAULT = 18;
    localparam int SB_LFAULT = 19;

    localparam int ADDR_STATUS = 0;
    localparam int ADDR_MASK   = 1;
    localparam int CNT_BASE    = 2;

    typedef enum logic [2:0] {
        BIN_NONE, BIN_64, BIN_127, BIN_255, BIN_511, BIN_1023, BIN_1522, BIN_JUMBO
    } len_bin_e;

    typedef struct packed {
        logic             valid;
        logic [LEN_W-1:0] len;
        logic             crc_err;
        logic             oversize;
        logic             bcast;
        logic             mcast;
        logic             frag;
    } frame_evt_t;

    typedef struct packed {
        logic overflow;
        logic underflow;
        logic code_viol;
        logic link_fault;
        logic remote_fault;
        logic local_fault;
    } line_evt_t;

    function automatic len_bin_e classify_len(input logic [LEN_W-1:0] len);
        if (len == LEN_W'(64))        return BIN_64;
        else if (len < LEN_W'(64))    return BIN_NONE;
        else if (len <= LEN_W'(127))  return BIN_127;
        else if (len <= LEN_W'(255))  return BIN_255;
        else if (len <= LEN_W'(511))  return BIN_511;
        else if (len <= LEN_W'(1023)) return BIN_1023;
        else if (len <= LEN_W'(1522)) return BIN_1522;
        else                          return BIN_JUMBO;
    endfunction

    // Status bit that reports a given counter as full.
    function automatic int full_bit(input int idx);
        case (idx)
            0:  return 3;
            1:  return 4;
            2:  return 6;
            3:  return 7;
            4:  return 8;
            5:  return 9;
            6:  return 10;
            7:  return 11;
            8:  return 12;
            9:  return 13;
            10: return 14;
            11: return 15;
            12: return 17;
            13: return 20;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/rxs_evt_decode.sv
`timescale 1ns/1ps
module rxs_evt_decode
    import rxs_pkg::*;
(
    input  frame_evt_t         frame,
    input  line_evt_t          line,
    output logic [NUM_CNT-1:0] inc_vec,
    output logic [LEN_W-1:0]   byte_amt,
    output logic [STAT_W-1:0]  evt_set
);
    len_bin_e bin;

    always_comb begin
        bin     = classify_len(frame.len);
        inc_vec = '0;
        inc_vec[CI_CRC]    = frame.valid & frame.crc_err;
        inc_vec[CI_MAXSZ]  = frame.valid & frame.oversize;
        inc_vec[CI_BYTES]  = frame.valid;
        inc_vec[CI_BCAST]  = frame.valid & frame.bcast;
        inc_vec[CI_MCAST]  = frame.valid & frame.mcast;
        inc_vec[CI_FRAG]   = frame.valid & frame.frag;
        inc_vec[CI_LFAULT] = line.link_fault;
        if (frame.valid) begin
            case (bin)
                BIN_64:    inc_vec[CI_H1] = 1'b1;
                BIN_127:   inc_vec[CI_H2] = 1'b1;
                BIN_255:   inc_vec[CI_H3] = 1'b1;
                BIN_511:   inc_vec[CI_H4] = 1'b1;
                BIN_1023:  inc_vec[CI_H5] = 1'b1;
                BIN_1522:  inc_vec[CI_H6] = 1'b1;
                BIN_JUMBO: inc_vec[CI_H7] = 1'b1;
                default:   ;
            endcase
        end
        byte_amt = frame.valid ? frame.len : '0;

        evt_set            = '0;
        evt_set[SB_FRAME]  = frame.valid;
        evt_set[SB_OVF]    = line.overflow;
        evt_set[SB_UNF]    = line.underflow;
        evt_set[SB_CODEV]  = line.code_viol;
        evt_set[SB_RFAULT] = line.remote_fault;
        evt_set[SB_LFAULT] = line.local_fault;
    end
endmodule

// File: rtl/rxs_sat_counter.sv
`timescale 1ns/1ps
module rxs_sat_counter #(
    parameter int W     = 8,
    parameter int AMT_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     cnt,
    output logic             full
);
    localparam int SUM_W = ((W > AMT_W) ? W : AMT_W) + 1;
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'({W{1'b1}});

    logic [SUM_W-1:0] sum;

    always_comb sum = SUM_W'(cnt) + SUM_W'(amt);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= (sum > LIMIT) ? '1 : W'(sum);
        end
    end

    assign full = (cnt == '1);

    // R3: a full counter stays full unless cleared
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (full && !clr) |=> full);

    // R7: a cleared counter reads zero next cycle
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    // R2: no event, no change
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> $stable(cnt));
endmodule

// File: rtl/rxs_status_irq.sv
`timescale 1ns/1ps
module rxs_status_irq
    import rxs_pkg::*;
#(
    parameter logic [STAT_W-1:0] MASK_INIT = STAT_W'(1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] set_vec,
    input  logic              rd_clear,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] mask,
    output logic              irq
);
    logic [STAT_W-1:0] active;

    always_comb active = status & ~mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= MASK_INIT;
            irq    <= 1'b0;
        end else begin
            status <= (rd_clear ? '0 : status) | set_vec;
            if (mask_wr) mask <= mask_wdata;
            irq <= |active;
        end
    end

    // R5: any source active in a cycle shows in status next cycle
    a_r5_set_lands: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(set_vec)) == $past(set_vec)));

    // R6: without a read, no status bit is lost
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        !rd_clear |=> ((status & $past(status)) == $past(status)));

    // R6: a read with nothing pending empties the status word
    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_clear && (set_vec == '0)) |=> (status == '0));

    // R9: an unmasked pending bit raises irq next cycle
    a_r9_raise: assert property (@(posedge clk) disable iff (rst)
        ((status & ~mask) != '0) |=> irq);

    // R9: a fully masked bank keeps irq low
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        (&mask) |=> !irq);

    // R8: the mask leaves reset with only bit 0 set
    a_r8_mask_reset: assert property (@(posedge clk)
        $fell(rst) |-> (mask == STAT_W'(1)));
endmodule

// File: rtl/rxs_stat_irq_bank.sv
`timescale 1ns/1ps
module rxs_stat_irq_bank
    import rxs_pkg::*;
#(
    parameter int W_ERR  = 8,
    parameter int W_BYTE = 32,
    parameter int W_FRM  = 21,
    parameter int W_H3   = 20,
    parameter int W_H4   = 19,
    parameter int W_H5   = 18,
    parameter int W_H6   = 17,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              frm_crc_err,
    input  logic              frm_oversize,
    input  logic              frm_bcast,
    input  logic              frm_mcast,
    input  logic              frm_frag,
    input  logic              evt_overflow,
    input  logic              evt_underflow,
    input  logic              evt_code_viol,
    input  logic              evt_link_fault,
    input  logic              evt_remote_fault,
    input  logic              evt_local_fault,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    output logic              irq
);
    localparam int CNT_END = CNT_BASE + NUM_CNT;
    localparam int IDX_W   = $clog2(NUM_CNT);

    function automatic int cnt_width(input int idx);
        case (idx)
            0, 1, 12: return W_ERR;
            2:        return W_BYTE;
            5:        return W_H3;
            6:        return W_H4;
            7:        return W_H5;
            8:        return W_H6;
            default:  return W_FRM;
        endcase
    endfunction

    frame_evt_t frame;
    line_evt_t  line;

    always_comb begin
        frame.valid        = frm_valid;
        frame.len          = frm_len;
        frame.crc_err      = frm_crc_err;
        frame.oversize     = frm_oversize;
        frame.bcast        = frm_bcast;
        frame.mcast        = frm_mcast;
        frame.frag         = frm_frag;
        line.overflow      = evt_overflow;
        line.underflow     = evt_underflow;
        line.code_viol     = evt_code_viol;
        line.link_fault    = evt_link_fault;
        line.remote_fault  = evt_remote_fault;
        line.local_fault   = evt_local_fault;
    end

    logic [NUM_CNT-1:0] inc_vec;
    logic [LEN_W-1:0]   byte_amt;
    logic [STAT_W-1:0]  evt_set;

    rxs_evt_decode u_decode (
        .frame    (frame),
        .line     (line),
        .inc_vec  (inc_vec),
        .byte_amt (byte_amt),
        .evt_set  (evt_set)
    );

    logic [NUM_CNT-1:0] clr_vec;
    logic [NUM_CNT-1:0] full_flags;
    logic [REG_W-1:0]   cnt_ext [NUM_CNT];

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        localparam int CW = cnt_width(gi);
        localparam int AW = (gi == int'(CI_BYTES)) ? LEN_W : 1;
        logic [CW-1:0] value;
        logic [AW-1:0] amt;

        if (gi == int'(CI_BYTES)) begin : g_amt_len
            assign amt = byte_amt;
        end else begin : g_amt_one
            assign amt = 1'b1;
        end

        assign clr_vec[gi] = host_wr && (int'(host_addr) == CNT_BASE + gi);

        rxs_sat_counter #(.W(CW), .AMT_W(AW)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr_vec[gi]),
            .inc  (inc_vec[gi]),
            .amt  (amt),
            .cnt  (value),
            .full (full_flags[gi])
        );

        assign cnt_ext[gi] = REG_W'(value);
    end

    logic [STAT_W-1:0] full_set;
    logic [STAT_W-1:0] set_vec;

    always_comb begin
        full_set = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            full_set[full_bit(i)] = full_set[full_bit(i)] | full_flags[i];
        end
        set_vec = full_set | evt_set;
    end

    logic              rd_clear;
    logic              mask_wr;
    logic [STAT_W-1:0] status;
    logic [STAT_W-1:0] mask;
    logic              unused_wdata_hi;

    assign rd_clear        = host_rd && (int'(host_addr) == ADDR_STATUS);
    assign mask_wr         = host_wr && (int'(host_addr) == ADDR_MASK);
    assign unused_wdata_hi = ^host_wdata[REG_W-1:STAT_W];

    rxs_status_irq u_status (
        .clk        (clk),
        .rst        (rst),
        .set_vec    (set_vec),
        .rd_clear   (rd_clear),
        .mask_wr    (mask_wr),
        .mask_wdata (host_wdata[STAT_W-1:0]),
        .status     (status),
        .mask       (mask),
        .irq        (irq)
    );

    logic [IDX_W-1:0] sel;

    always_comb begin
        sel        = IDX_W'(int'(host_addr) - CNT_BASE);
        host_rdata = '0;
        if (int'(host_addr) == ADDR_STATUS) begin
            host_rdata = REG_W'(status);
        end else if (int'(host_addr) == ADDR_MASK) begin
            host_rdata = REG_W'(mask);
        end else if (int'(host_addr) >= CNT_BASE && int'(host_addr) < CNT_END) begin
            host_rdata = cnt_ext[sel];
        end
    end

    // R10: addresses past the counters read zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (int'(host_addr) >= CNT_END) |-> (host_rdata == '0));

    // R4: every full counter lands on its status bit next cycle
    a_r4_full_to_status: assert property (@(posedge clk) disable iff (rst)
        (|full_flags) |=> ((status & $past(full_set)) == $past(full_set)));
endmodule

// File: tb/rxs_stat_irq_bank_test.sv
`timescale 1ns/1ps
module rxs_stat_irq_bank_test;
    localparam int NC = 14;
    localparam int TB_W_ERR = 3, TB_W_BYTE = 10, TB_W_FRM = 4;
    localparam int TB_W_H3 = 4, TB_W_H4 = 3, TB_W_H5 = 3, TB_W_H6 = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        frm_valid = 0, frm_crc_err = 0, frm_oversize = 0;
    logic        frm_bcast = 0, frm_mcast = 0, frm_frag = 0;
    logic [15:0] frm_len = '0;
    logic        evt_overflow = 0, evt_underflow = 0, evt_code_viol = 0;
    logic        evt_link_fault = 0, evt_remote_fault = 0, evt_local_fault = 0;
    logic        host_wr = 0, host_rd = 0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;

    rxs_stat_irq_bank #(
        .W_ERR(TB_W_ERR), .W_BYTE(TB_W_BYTE), .W_FRM(TB_W_FRM),
        .W_H3(TB_W_H3), .W_H4(TB_W_H4), .W_H5(TB_W_H5), .W_H6(TB_W_H6), .ADDR_W(5)
    ) uut (
        .clk(clk), .rst(rst),
        .frm_valid(frm_valid), .frm_len(frm_len), .frm_crc_err(frm_crc_err),
        .frm_oversize(frm_oversize), .frm_bcast(frm_bcast), .frm_mcast(frm_mcast),
        .frm_frag(frm_frag), .evt_overflow(evt_overflow), .evt_underflow(evt_underflow),
        .evt_code_viol(evt_code_viol), .evt_link_fault(evt_link_fault),
        .evt_remote_fault(evt_remote_fault), .evt_local_fault(evt_local_fault),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    int tests = 0, fails = 0;
    bit done = 0;

    // Reference model state
    longint      mcnt[NC];
    longint      mmax[NC];
    int          cw[NC]   = '{TB_W_ERR, TB_W_ERR, TB_W_BYTE, TB_W_FRM, TB_W_FRM, TB_W_H3, TB_W_H4,
                              TB_W_H5, TB_W_H6, TB_W_FRM, TB_W_FRM, TB_W_FRM, TB_W_ERR, TB_W_FRM};
    int          fbit[NC] = '{3, 4, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15, 17, 20};
    logic [20:0] mstat, mmask;
    logic        mirq;

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int len_bin(input int len);
        if (len == 64) return 1;
        if (len < 64) return 0;
        if (len <= 127) return 2;
        if (len <= 255) return 3;
        if (len <= 511) return 4;
        if (len <= 1023) return 5;
        if (len <= 1522) return 6;
        return 7;
    endfunction

    function automatic longint model_inc(input int i);
        int b = len_bin(int'(frm_len));
        case (i)
            0:  return longint'(frm_valid && frm_crc_err);
            1:  return longint'(frm_valid && frm_oversize);
            2:  return frm_valid ? longint'(frm_len) : 0;
            9:  return longint'(frm_valid && frm_bcast);
            10: return longint'(frm_valid && frm_mcast);
            11: return longint'(frm_valid && frm_frag);
            12: return longint'(evt_link_fault);
            13: return longint'(frm_valid && b == 7);
            default: return longint'(frm_valid && b == i - 2);
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NC; i++) begin
            mcnt[i] = 0;
            mmax[i] = (longint'(1) << cw[i]) - 1;
        end
        mstat = '0;
        mmask = 21'h1;
        mirq  = 1'b0;
    endtask

    // Compare outputs mid-cycle, advance model and design by one edge.
    task automatic tick();
        logic [31:0] exp_rd;
        string       tag;
        longint      ncnt[NC];
        logic [20:0] nstat, nmask;
        logic        nirq;
        int          a;
        #1;
        a = int'(host_addr);
        check("R9", "irq", {31'b0, irq}, {31'b0, mirq});
        if (a == 0) begin exp_rd = {11'b0, mstat}; tag = "R6"; end
        else if (a == 1) begin exp_rd = {11'b0, mmask}; tag = "R8"; end
        else if (a < 16) begin
            exp_rd = 32'(mcnt[a-2]);
            tag = ((a >= 5 && a <= 10) || a == 15) ? "R1" : "R2";
        end else begin exp_rd = '0; tag = "R10"; end
        check(tag, $sformatf("rdata@%0d", a), host_rdata, exp_rd);

        nirq  = |(mstat & ~mmask);
        nstat = (host_rd && a == 0) ? '0 : mstat;
        for (int i = 0; i < NC; i++) if (mcnt[i] == mmax[i]) nstat[fbit[i]] = 1'b1;
        if (frm_valid)        nstat[0]  = 1'b1;
        if (evt_overflow)     nstat[1]  = 1'b1;
        if (evt_underflow)    nstat[2]  = 1'b1;
        if (evt_code_viol)    nstat[5]  = 1'b1;
        if (evt_remote_fault) nstat[18] = 1'b1;
        if (evt_local_fault)  nstat[19] = 1'b1;
        for (int i = 0; i < NC; i++) begin
            if (host_wr && a == i + 2) ncnt[i] = 0;
            else begin
                ncnt[i] = mcnt[i] + model_inc(i);
                if (ncnt[i] > mmax[i]) ncnt[i] = mmax[i];
            end
        end
        nmask = (host_wr && a == 1) ? host_wdata[20:0] : mmask;

        @(posedge clk);
        #1;
        for (int i = 0; i < NC; i++) mcnt[i] = ncnt[i];
        mstat = nstat; mmask = nmask; mirq = nirq;
        @(negedge clk);
        frm_valid = 0; frm_crc_err = 0; frm_oversize = 0; frm_bcast = 0; frm_mcast = 0;
        frm_frag = 0; frm_len = '0; evt_overflow = 0; evt_underflow = 0; evt_code_viol = 0;
        evt_link_fault = 0; evt_remote_fault = 0; evt_local_fault = 0;
        host_wr = 0; host_rd = 0;
    endtask

    task automatic frame(input int len, input bit crc, input bit ovs, input bit bc,
                         input bit mc, input bit frag);
        frm_valid = 1; frm_len = 16'(len); frm_crc_err = crc; frm_oversize = ovs;
        frm_bcast = bc; frm_mcast = mc; frm_frag = frag;
        tick();
    endtask

    task automatic peek(input int addr);
        host_addr = 5'(addr);
        tick();
    endtask

    task automatic read_status();
        host_addr = 5'd0; host_rd = 1;
        tick();
    endtask

    task automatic write_reg(input int addr, input logic [31:0] data);
        host_addr = 5'(addr); host_wr = 1; host_wdata = data;
        tick();
    endtask

    task automatic sweep();
        for (int a = 0; a < 18; a++) peek(a);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R8: reset mask value; R6: status empty after reset
        peek(1);
        peek(0);
        // R1: histogram bin boundaries, below-64 frame lands nowhere
        frame(64, 0, 0, 1, 0, 0);
        frame(65, 0, 0, 0, 1, 0);
        frame(127, 1, 0, 0, 0, 0);
        frame(128, 0, 0, 0, 0, 0);
        frame(255, 0, 1, 0, 0, 0);
        frame(256, 0, 0, 1, 1, 0);
        frame(511, 0, 0, 0, 0, 0);
        frame(512, 0, 0, 0, 0, 0);
        frame(1023, 0, 0, 0, 0, 0);
        frame(1024, 0, 0, 0, 0, 0);
        frame(1522, 0, 0, 0, 0, 0);
        frame(1523, 0, 1, 0, 0, 0);
        frame(40, 0, 0, 0, 0, 1);
        sweep();
        // R3: byte counter overshoot saturates; R4: its full bit 6 sets
        read_status();
        peek(0);
        // R7: write clears a counter
        write_reg(4, 32'hFFFF_FFFF);
        peek(4);
        // R2 and R3: small frames accumulate bytes up to saturation
        for (int k = 0; k < 20; k++) frame(64, 0, 0, 0, 0, 0);
        peek(4);
        // R3 and R4: CRC counter saturates, status bit 3, irq follows
        write_reg(2, 0);
        for (int k = 0; k < 9; k++) frame(70, 1, 0, 0, 0, 0);
        peek(2);
        peek(0);
        // R6: read clears, full counter sets its bit again
        read_status();
        peek(0);
        write_reg(2, 0);
        read_status();
        peek(0);
        // R7: clear wins over same-cycle increment
        host_addr = 5'd2; host_wr = 1; host_wdata = 0;
        frm_valid = 1; frm_len = 16'd80; frm_crc_err = 1;
        tick();
        peek(2);
        // R5: each event strobe sets its own status bit
        evt_overflow = 1; tick();
        evt_underflow = 1; tick();
        evt_code_viol = 1; tick();
        evt_remote_fault = 1; tick();
        evt_local_fault = 1; tick();
        peek(0);
        // R2 and R4: link-fault counter fills to bit 17
        for (int k = 0; k < 9; k++) begin evt_link_fault = 1; tick(); end
        peek(14);
        peek(0);
        // R6: remote fault during the read cycle sets again
        host_addr = 5'd0; host_rd = 1; evt_remote_fault = 1;
        tick();
        peek(0);
        // R9: full mask holds irq low, unmasking raises it
        write_reg(1, 32'h001F_FFFF);
        peek(1);
        evt_overflow = 1; tick();
        peek(0);
        peek(0);
        write_reg(1, 32'h0000_0000);
        peek(0);
        peek(0);
        // R10: write to status address has no effect; unmapped reads zero
        for (int i = 0; i < NC; i++) write_reg(i + 2, 0);
        read_status();
        read_status();
        write_reg(0, 32'hFFFF_FFFF);
        peek(0);
        peek(16);
        peek(31);
        // R9: only frame-received source, masked by bit 0
        write_reg(1, 32'h1);
        frame(30, 0, 0, 0, 0, 0);
        peek(0);
        peek(0);
        sweep();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule